// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

This block gathers one-cycle event pulses from many on-chip sources into three 32-bit pending banks and turns them into three level-sensitive interrupt lines, `irq_a` (most urgent), `irq_b` and `irq_c` (least urgent). Each event arrives as a 7-bit code. The two upper bits pick the bank and the five lower bits pick the bit inside it. A pending bit stays set until software clears it.

Every line has its own mask word for each bank, which gives nine mask words. A line is high whenever any bank holds a pending bit that the line's mask for that bank also enables. The line is recomputed from the stored state after each edge. Clearing a bit in one bank therefore leaves a line high while another bank still drives it, and writing a mask takes effect at once. The block has no arbitration between the three lines: a downstream interrupt controller ranks them.

Software reaches the block through a small word-addressed register port. Writes complete in one cycle and reads are combinational. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block sees it two clock edges after `rst_n` rises.

Top module: `evt_irq_agg`

## Requirements
- R1: Event code bits [6:5] pick the bank (0, 1 or 2) and bits [4:0] pick the bit. A valid event whose bank field is 3 changes no state.
- R2: A valid event sets its pending bit at the next clock edge and leaves every other pending bit as it was.
- R3: A write to word offset 0, 1 or 2 clears the bits of that pending bank that are 1 in the write data. Bits written as 0 keep their value.
- R4: When an event sets a bit in the same cycle that a write clears that bit, the bit ends up set.
- R5: The mask words for `irq_a` sit at offsets 4 to 6, those for `irq_b` at 8 to 10 and those for `irq_c` at 12 to 14, each at base plus bank. Each is a full 32-bit read/write register.
- R6: Each interrupt line equals the OR over all three banks of (pending AND that line's mask for the bank). The value is taken from the registers as updated at the latest clock edge.
- R7: After a pending clear, a line stays high while any bank still has a bit that its mask enables. The line goes low in the cycle after the clear that removes the last such bit.
- R8: A mask write that enables a bit that is already pending raises the line in the cycle right after the write.
- R9: `bus_rdata` shows the register at `bus_addr` without delay. A read has no side effect. Offsets whose bank field [1:0] is 3 read as zero.
- R10: After reset, all pending bits, all mask words and all three lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| evt_valid | input | 1 | Event pulse qualifier |
| evt_code | input | 7 | Event code: [6:5] bank, [4:0] bit |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 4 | Word offset: [3:2] group (0 pending, 1 A, 2 B, 3 C), [1:0] bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_a | output | 1 | Highest-priority interrupt level |
| irq_b | output | 1 | Middle-priority interrupt level |
| irq_c | output | 1 | Lowest-priority interrupt level |

## Verification
A pending or mask bit that holds a wrong value shows up on `bus_rdata` as soon as that offset is read. It also shows up on an interrupt line in the same cycle, but only when the corresponding bit in the other word (mask or pending) is set. The bench therefore mixes dense masks with sparse ones and reads addresses on every cycle, so a bit that is wrongly kept or wrongly cleared becomes visible within a cycle or two. The model is compared against all three lines and the read data on every clock. Any error in set/clear ordering, bank decoding or cross-bank OR therefore shows up at the edge where the error first happens.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  localparam int unsigned BANKS  = 3;
  localparam int unsigned BITS   = 32;
  localparam int unsigned OUTS   = 3;
  localparam int unsigned BANK_W = $clog2(BANKS + 1);
  localparam int unsigned IDX_W  = $clog2(BITS);
  localparam int unsigned CODE_W = BANK_W + IDX_W;
  localparam int unsigned GRP_W  = $clog2(OUTS + 1);
  localparam int unsigned ADDR_W = GRP_W + BANK_W;
  typedef logic [BITS-1:0] word_t;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/evt_code_dec.sv
module evt_code_dec #(
  parameter int unsigned BANKS  = evt_agg_pkg::BANKS,
  parameter int unsigned BITS   = evt_agg_pkg::BITS,
  parameter int unsigned BANK_W = evt_agg_pkg::BANK_W,
  parameter int unsigned IDX_W  = evt_agg_pkg::IDX_W,
  localparam int unsigned CODE_W = BANK_W + IDX_W
) (
  input  logic                        valid,
  input  logic [CODE_W-1:0]           code,
  output logic [BANKS-1:0][BITS-1:0]  set_vec
);
  logic [BANK_W-1:0] bank_f;
  logic [IDX_W-1:0]  idx_f;

  assign bank_f = code[CODE_W-1:IDX_W];
  assign idx_f  = code[IDX_W-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign set_vec[b] = (valid && bank_f == BANK_W'(b)) ? (BITS'(1) << idx_f) : '0;
  end
endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int unsigned BITS = evt_agg_pkg::BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] set_bits,
  input  logic [BITS-1:0] clr_bits,
  output logic [BITS-1:0] pend
);
  logic [BITS-1:0] pend_d;
  logic            upd_en;

  // Clear first, then set: a same-cycle event survives a clear.
  always_comb begin
    upd_en = (|set_bits) || (|clr_bits);
    pend_d = (pend & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= '0;
    else if (upd_en) pend <= pend_d;
  end
endmodule

// File: rtl/evt_mask_word.sv
module evt_mask_word #(
  parameter int unsigned BITS = evt_agg_pkg::BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [BITS-1:0] wdata,
  output logic [BITS-1:0] value
);
  logic [BITS-1:0] value_d;

  always_comb value_d = we ? wdata : value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= '0;
    else if (we) value <= value_d;
  end
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
  parameter int unsigned BANKS = evt_agg_pkg::BANKS,
  parameter int unsigned BITS  = evt_agg_pkg::BITS,
  parameter int unsigned OUTS  = evt_agg_pkg::OUTS
) (
  input  logic [BANKS-1:0][BITS-1:0]            pend,
  input  logic [OUTS-1:0][BANKS-1:0][BITS-1:0]  mask,
  output logic [OUTS-1:0]                       irq
);
  logic [OUTS-1:0][BANKS-1:0] hit;

  for (genvar o = 0; o < OUTS; o++) begin : g_out
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign hit[o][b] = |(pend[b] & mask[o][b]);
    end
    assign irq[o] = |hit[o];
  end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int unsigned BANKS  = evt_agg_pkg::BANKS,
  parameter int unsigned BITS   = evt_agg_pkg::BITS,
  parameter int unsigned OUTS   = evt_agg_pkg::OUTS,
  parameter int unsigned BANK_W = evt_agg_pkg::BANK_W,
  parameter int unsigned IDX_W  = evt_agg_pkg::IDX_W,
  parameter int unsigned GRP_W  = evt_agg_pkg::GRP_W,
  localparam int unsigned CODE_W = BANK_W + IDX_W,
  localparam int unsigned ADDR_W = GRP_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BITS-1:0]   bus_wdata,
  output logic [BITS-1:0]   bus_rdata,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_c
);
  logic                                rst_sync_n;
  logic [BANKS-1:0][BITS-1:0]          set_vec;
  logic [BANKS-1:0][BITS-1:0]          clr_vec;
  logic [BANKS-1:0][BITS-1:0]          pend_q;
  logic [OUTS-1:0][BANKS-1:0][BITS-1:0] mask_q;
  logic [OUTS-1:0][BANKS-1:0]          mask_we;
  logic [OUTS-1:0]                     irq_vec;
  logic [GRP_W-1:0]                    grp_f;
  logic [BANK_W-1:0]                   bank_f;
  logic                                wr_hit;

  assign grp_f  = bus_addr[ADDR_W-1:BANK_W];
  assign bank_f = bus_addr[BANK_W-1:0];
  assign wr_hit = bus_sel && bus_wr;

  evt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evt_code_dec #(.BANKS(BANKS), .BITS(BITS), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_dec (
    .valid   (evt_valid),
    .code    (evt_code),
    .set_vec (set_vec)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_pend
    assign clr_vec[b] = (wr_hit && grp_f == '0 && bank_f == BANK_W'(b)) ? bus_wdata : '0;

    evt_pend_bank #(.BITS(BITS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .set_bits (set_vec[b]),
      .clr_bits (clr_vec[b]),
      .pend     (pend_q[b])
    );
  end

  for (genvar o = 0; o < OUTS; o++) begin : g_mgrp
    for (genvar b = 0; b < BANKS; b++) begin : g_mbank
      assign mask_we[o][b] = wr_hit && grp_f == GRP_W'(o + 1) && bank_f == BANK_W'(b);

      evt_mask_word #(.BITS(BITS)) u_mask (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .we    (mask_we[o][b]),
        .wdata (bus_wdata),
        .value (mask_q[o][b])
      );
    end
  end

  evt_irq_merge #(.BANKS(BANKS), .BITS(BITS), .OUTS(OUTS)) u_merge (
    .pend (pend_q),
    .mask (mask_q),
    .irq  (irq_vec)
  );

  assign irq_a = irq_vec[0];
  assign irq_b = irq_vec[1];
  assign irq_c = irq_vec[2];

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_f == BANK_W'(b)) begin
        if (grp_f == '0) bus_rdata = pend_q[b];
        for (int o = 0; o < OUTS; o++) begin
          if (grp_f == GRP_W'(o + 1)) bus_rdata = mask_q[o][b];
        end
      end
    end
  end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
  parameter int unsigned BANKS = 3,
  parameter int unsigned BITS  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       evt_valid,
  input logic [6:0]                 evt_code,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic [3:0]                 bus_addr,
  input logic [BITS-1:0]            bus_wdata,
  input logic [BITS-1:0]            bus_rdata,
  input logic [BANKS-1:0][BITS-1:0] pend,
  input logic [2:0]                 irq
);
  logic [BANKS*BITS-1:0] pend_flat;
  logic [BANKS*BITS-1:0] clr_flat;
  logic [6:0]            code_q;
  logic                  pend_wr;
  logic                  mask_wr;
  logic                  evt_live;

  assign pend_flat = pend;
  assign pend_wr   = bus_sel && bus_wr && bus_addr[3:2] == 2'd0;
  assign mask_wr   = bus_sel && bus_wr && bus_addr[3:2] != 2'd0;
  assign evt_live  = evt_valid && evt_code[6:5] != 2'd3;

  always_comb begin
    clr_flat = '0;
    if (pend_wr && bus_addr[1:0] != 2'd3)
      clr_flat[int'(bus_addr[1:0])*BITS +: BITS] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= evt_code;
  end

  a_r1_bank3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code[6:5] == 2'd3 && !pend_wr) |=> $stable(pend_flat));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_live |=> pend_flat[code_q]);

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && !evt_valid) |=> ((pend_flat & $past(clr_flat)) == '0));

  a_r3_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && !evt_valid) |=> ((pend_flat & ~$past(clr_flat)) == ($past(pend_flat) & ~$past(clr_flat))));

  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq && !pend_wr && !mask_wr) |=> ((irq & $past(irq)) == $past(irq)));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] == 2'd3) |-> (bus_rdata == '0));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.BANKS(BANKS), .BITS(BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .evt_valid (evt_valid),
  .evt_code  (evt_code),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pend      (pend_q),
  .irq       ({irq_c, irq_b, irq_a})
);

// File: tb/sim_evt_irq_agg.sv
`timescale 1ns/1ps
module sim_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [6:0]  evt_code;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_a, irq_b, irq_c;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  evt_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c)
  );

  // Behavioural reference: mask index [line][bank]
  logic [31:0] m_pend [3];
  logic [31:0] m_mask [3][3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_pend[i] = 0;
        for (int j = 0; j < 3; j++) m_mask[i][j] = 0;
      end
    end else begin
      if (bus_sel && bus_wr && bus_addr[1:0] != 2'd3) begin
        if (bus_addr[3:2] == 0) m_pend[bus_addr[1:0]] = m_pend[bus_addr[1:0]] & ~bus_wdata;
        else m_mask[bus_addr[3:2]-1][bus_addr[1:0]] = bus_wdata;
      end
      if (evt_valid && evt_code[6:5] != 2'd3)
        m_pend[evt_code[6:5]][evt_code[4:0]] = 1'b1;
    end
  end

  function automatic bit exp_irq(int line);
    bit r = 0;
    for (int b = 0; b < 3; b++) if ((m_pend[b] & m_mask[line][b]) != 0) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rdata(logic [3:0] a);
    if (a[1:0] == 2'd3) return 32'h0;
    if (a[3:2] == 0) return m_pend[a[1:0]];
    return m_mask[a[3:2]-1][a[1:0]];
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance one clock; compare against the model shortly after the edge.
  task automatic tick();
    @(posedge clk);
    #4;
    check({31'd0, irq_a}, {31'd0, exp_irq(0)}, "R6 irq_a");
    check({31'd0, irq_b}, {31'd0, exp_irq(1)}, "R6 irq_b");
    check({31'd0, irq_c}, {31'd0, exp_irq(2)}, "R6 irq_c");
    check(bus_rdata, exp_rdata(bus_addr), "R9 rdata");
  endtask

  task automatic post(logic [6:0] c);
    evt_valid = 1; evt_code = c; tick(); evt_valid = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] e, string tag);
    bus_sel = 1; bus_addr = a; tick(); bus_sel = 0;
    check(bus_rdata, e, tag);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog: actual=timeout expected=finish");
    errors++;
    checks++;
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_valid = 0; evt_code = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    #4 rst_n = 1;
    repeat (4) tick();

    // R10: reset state
    check({29'd0, irq_c, irq_b, irq_a}, 32'd0, "R10 lines");
    for (int a = 0; a < 16; a++) rd(4'(a), 32'd0, "R10 regs");

    // R1 / R2: decode and accumulation
    post(7'h03);
    rd(4'd0, 32'h0000_0008, "R2 bank0 bit3");
    post(7'd95);
    rd(4'd2, 32'h8000_0000, "R1 bank2 bit31");
    post(7'd32);
    rd(4'd1, 32'h0000_0001, "R1 bank1 bit0");
    post(7'd101);
    rd(4'd0, 32'h0000_0008, "R1 bank3 ignored b0");
    rd(4'd1, 32'h0000_0001, "R1 bank3 ignored b1");
    rd(4'd2, 32'h8000_0000, "R1 bank3 ignored b2");
    post(7'h00);
    rd(4'd0, 32'h0000_0009, "R2 accumulate");
    check({29'd0, irq_c, irq_b, irq_a}, 32'd0, "R6 unmasked quiet");

    // R8: unmasking pending bits raises the lines at once
    wr(4'd5, 32'h1);
    check({31'd0, irq_a}, 32'd1, "R8 irq_a");
    wr(4'd8, 32'h8);
    check({31'd0, irq_b}, 32'd1, "R8 irq_b");
    wr(4'd14, 32'h8000_0000);
    check({31'd0, irq_c}, 32'd1, "R8 irq_c");
    wr(4'd6, 32'h8000_0000);
    rd(4'd5, 32'h1, "R5 mask A bank1");
    rd(4'd14, 32'h8000_0000, "R5 mask C bank2");
    rd(4'd8, 32'h8, "R5 mask B bank0");

    // R3 / R7: clears and cross-bank hold
    wr(4'd0, 32'h8);
    check({31'd0, irq_b}, 32'd0, "R7 irq_b drop");
    rd(4'd0, 32'h1, "R3 partial clear");
    wr(4'd1, 32'hFFFF_FFFF);
    check({31'd0, irq_a}, 32'd1, "R7 irq_a held by bank2");
    wr(4'd2, 32'h8000_0000);
    check({31'd0, irq_a}, 32'd0, "R7 irq_a drop");
    check({31'd0, irq_c}, 32'd0, "R7 irq_c drop");

    // R4: set beats same-cycle clear
    post(7'd69);
    evt_valid = 1; evt_code = 7'd69;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'd2; bus_wdata = 32'h20;
    tick();
    evt_valid = 0; bus_sel = 0; bus_wr = 0;
    rd(4'd2, 32'h20, "R4 set wins");

    // R3: mixed clear pattern
    post(7'd4); post(7'd7);
    rd(4'd0, 32'h91, "R3 before");
    wr(4'd0, 32'h81);
    rd(4'd0, 32'h10, "R3 mixed clear");

    // R9: unmapped offsets and side-effect-free reads
    rd(4'd3, 32'd0, "R9 off3");
    rd(4'd7, 32'd0, "R9 off7");
    rd(4'd11, 32'd0, "R9 off11");
    rd(4'd15, 32'd0, "R9 off15");
    rd(4'd0, 32'h10, "R9 read no side effect");

    // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8)
    for (int n = 0; n < 3000; n++) begin
      evt_valid = ($urandom_range(0, 2) == 0);
      evt_code  = 7'($urandom);
      bus_sel   = ($urandom_range(0, 3) == 0);
      bus_wr    = bus_sel && ($urandom_range(0, 1) == 1);
      bus_addr  = 4'($urandom);
      case ($urandom_range(0, 2))
        0: bus_wdata = 32'h1 << $urandom_range(0, 31);
        1: bus_wdata = $urandom;
        default: bus_wdata = 32'hFFFF_FFFF;
      endcase
      tick();
    end
    evt_valid = 0; bus_sel = 0; bus_wr = 0;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule